// File: doc/BRIEF.md
# Ultra DMA Status and Error Monitor

This block holds the 32-bit status word of an ATA/ATAPI host controller, together with the logic that sets its sticky error flags. It tracks whether a DMA transfer is running. It loads a transfer byte counter from a value that software programs, and it counts the counter down as data words are accepted. It samples the device handshake lines (data request and ready) whenever an Ultra DMA burst starts or ends, and flags any protocol violation it finds. It also flags a device that leaves Ultra DMA mode before the programmed byte count has been moved.

The block also guards the task-file port. While DMA is running, every task-file access is dropped without any trace on the device side: no strobe is issued, no shadow register is written and a read returns zero. The dropped access is recorded in a sticky software-error flag. Software reads the status word over a simple register bus and clears each sticky flag by writing 0 to its bit. The flags stay set until software clears them.

Top module: `udma_status_mon`

## Requirements
- R1: After reset every defined status bit reads 0. Status bits 31 to 9 and bit 6 always read 0.
- R2: The sticky flags are SWERR (bit 8), IFERR (bit 7), DEVTRM (bit 5), TOUT (bit 3), ERR (bit 2) and NEND (bit 1). A status write (address 0) with a 0 in a flag's bit clears that flag. A 1 in that bit leaves the flag unchanged. If the flag's set condition occurs in the same cycle as the clearing write, the flag ends up set.
- R3: A task-file access made while ACT is 1 sets SWERR on the next cycle. The access gives no tf_strobe, a read returns 0 and a write leaves the shadow register unchanged. When ACT is 0, an access asserts tf_strobe in the same cycle, a write stores tf_wdata at tf_addr, and a read returns the stored value.
- R4: While ACT is 1 and dir_in is 1, IFERR is set when host_end occurs with dreq=1 or iordy=0, or when dev_end occurs with iordy=0.
- R5: While ACT is 1 and dir_in is 0, IFERR is set when burst_start occurs with iordy=0, or when host_end occurs with dreq=1 or iordy=0. Burst strobes have no effect while ACT is 0.
- R6: ACT (bit 0) becomes 1 in the cycle after dma_start when ACT was 0 and the programmed count is nonzero. It becomes 0 in the cycle after the word_ack that exhausts the count, or in the cycle after dev_exit. A dma_start while ACT is 1 is ignored.
- R7: Each accepted word_ack decrements the remaining count by 2 bytes. NEND is set when the count is exhausted, and also when dma_start occurs with a programmed count of 0.
- R8: A dev_exit while ACT is 1 sets DEVTRM unless the word_ack in the same cycle exhausts the count.
- R9: The tout_evt and err_evt strobes set TOUT and ERR. DEVINT (bit 4) follows dev_irq, and writes to bit 4 have no effect on it.
- R10: Reads require cpu_rd=1, otherwise cpu_rdata is 0. Address 1 holds the programmed byte count in bits 15:0 and can be read and written. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 4 | Register word address |
| cpu_rd | input | 1 | Register read enable |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data |
| tf_req | input | 1 | Task-file access request |
| tf_we | input | 1 | Task-file access is a write |
| tf_addr | input | 3 | Task-file register index |
| tf_wdata | input | 16 | Task-file write data |
| tf_rdata | output | 16 | Task-file read data |
| tf_strobe | output | 1 | Device-side access strobe |
| dma_start | input | 1 | Start a DMA transfer |
| word_ack | input | 1 | One data word accepted |
| dev_exit | input | 1 | Device left Ultra DMA mode |
| dir_in | input | 1 | 1 = data-in transfer, 0 = data-out transfer |
| burst_start | input | 1 | Ultra DMA burst start event |
| host_end | input | 1 | Host terminated the burst |
| dev_end | input | 1 | Device terminated the burst |
| dreq | input | 1 | Sampled device data request line |
| iordy | input | 1 | Sampled device ready line |
| tout_evt | input | 1 | Timeout event strobe |
| err_evt | input | 1 | Error event strobe |
| dev_irq | input | 1 | Device interrupt level |

## Verification
Directed sequences drive every burst event in both directions, under all four combinations of dreq and iordy. They separate the data-in rules from the data-out rules: for example, dev_end matters only on data-in, and burst_start matters only on data-out. Further sequences end a transfer by exhausting the count and by dev_exit, including both in the same cycle. These separate NEND from DEVTRM. A long pseudo-random phase then mixes task-file traffic, status writes with random clear masks, and events that land in the same cycle as clears. These runs show whether clearing, set-wins priority and access blocking depend on ACT at the right cycle.

// File: rtl/udma_stat_pkg.sv
// Package: shared status bit positions and register addresses for the
// Ultra DMA status monitor. Bit positions are fixed because software decodes them.
package udma_stat_pkg;
    localparam int NUM_FLAGS = 6;
    localparam int POS_SWERR  = 8;
    localparam int POS_IFERR  = 7;
    localparam int POS_DEVTRM = 5;
    localparam int POS_DEVINT = 4;
    localparam int POS_TOUT   = 3;
    localparam int POS_ERR    = 2;
    localparam int POS_NEND   = 1;
    localparam int POS_ACT    = 0;
    // Sticky flag index -> status bit position
    localparam int FLAG_POS [NUM_FLAGS] = '{POS_SWERR, POS_IFERR, POS_DEVTRM,
                                            POS_TOUT, POS_ERR, POS_NEND};
    localparam int ADDR_STATUS = 0;
    localparam int ADDR_COUNT  = 1;
endpackage

// File: rtl/udma_xfer_count.sv
// Module: transfer byte counter and DMA-active tracker.
// Assumes: start is honoured only when idle; a start with count zero
// reports normal end at once and never goes active.
module udma_xfer_count #(
    parameter int CNT_W      = 16,
    parameter int WORD_BYTES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] prog_cnt,
    input  logic             word_ack,
    input  logic             dev_exit,
    output logic             active,
    output logic             nend_set,
    output logic             devtrm_set
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(WORD_BYTES);

    logic [CNT_W-1:0] remain_q;
    logic             ack, exhaust;

    // Decode completion and early device exit for this cycle
    always_comb begin
        ack        = active && word_ack;
        exhaust    = ack && (remain_q <= STEP);
        nend_set   = exhaust || (start && !active && (prog_cnt == '0));
        devtrm_set = active && dev_exit && !exhaust;
    end

    // Load, decrement and retire the transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            remain_q <= '0;
        end else if (!active) begin
            if (start && (prog_cnt != '0)) begin
                active   <= 1'b1;
                remain_q <= prog_cnt;
            end
        end else if (exhaust || dev_exit) begin
            active   <= 1'b0;
            remain_q <= '0;
        end else if (ack) begin
            remain_q <= remain_q - STEP;
        end
    end
endmodule

// File: rtl/udma_iferr_detect.sv
// Module: Ultra DMA handshake protocol checker (combinational).
// Assumes: dreq/iordy are already synchronised; events count only while active.
module udma_iferr_detect (
    input  logic active,
    input  logic dir_in,
    input  logic burst_start,
    input  logic host_end,
    input  logic dev_end,
    input  logic dreq,
    input  logic iordy,
    output logic iferr_set
);
    logic in_bad, out_bad;

    // Evaluate the illegal line states for each direction
    always_comb begin
        in_bad  = (host_end && (dreq || !iordy)) || (dev_end && !iordy);
        out_bad = (burst_start && !iordy) || (host_end && (dreq || !iordy));
        iferr_set = active && (dir_in ? in_bad : out_bad);
    end
endmodule

// File: rtl/udma_taskfile_gate.sv
// Module: task-file shadow registers with a DMA-time access blocker.
// Assumes: one access per request cycle; blocked accesses leave no trace.
module udma_taskfile_gate #(
    parameter int TF_AW = 3,
    parameter int TF_DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_active,
    input  logic             tf_req,
    input  logic             tf_we,
    input  logic [TF_AW-1:0] tf_addr,
    input  logic [TF_DW-1:0] tf_wdata,
    output logic [TF_DW-1:0] tf_rdata,
    output logic             tf_strobe,
    output logic             swerr_set
);
    localparam int TF_DEPTH = 1 << TF_AW;

    logic [TF_DW-1:0] shadow_q [TF_DEPTH];
    logic             allowed;

    // Decide whether the access may reach the device side
    always_comb begin
        allowed   = tf_req && !dma_active;
        swerr_set = tf_req && dma_active;
        tf_strobe = allowed;
        tf_rdata  = (allowed && !tf_we) ? shadow_q[tf_addr] : '0;
    end

    // Store permitted writes into the shadow file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TF_DEPTH; i++) shadow_q[i] <= '0;
        end else if (allowed && tf_we) begin
            shadow_q[tf_addr] <= tf_wdata;
        end
    end
endmodule

// File: rtl/udma_status_mon.sv
// Module: top of the Ultra DMA status monitor. Holds the sticky flags with
// write-0-to-clear behaviour, the count register and the read mux.
// Assumes: single-cycle register bus, reads are combinational.
module udma_status_mon
    import udma_stat_pkg::*;
#(
    parameter int CPU_AW     = 4,
    parameter int CNT_W      = 16,
    parameter int WORD_BYTES = 2,
    parameter int TF_AW      = 3,
    parameter int TF_DW      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    input  logic              tf_req,
    input  logic              tf_we,
    input  logic [TF_AW-1:0]  tf_addr,
    input  logic [TF_DW-1:0]  tf_wdata,
    output logic [TF_DW-1:0]  tf_rdata,
    output logic              tf_strobe,
    input  logic              dma_start,
    input  logic              word_ack,
    input  logic              dev_exit,
    input  logic              dir_in,
    input  logic              burst_start,
    input  logic              host_end,
    input  logic              dev_end,
    input  logic              dreq,
    input  logic              iordy,
    input  logic              tout_evt,
    input  logic              err_evt,
    input  logic              dev_irq
);
    logic                 active;
    logic                 nend_set, devtrm_set, iferr_set, swerr_set;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [CNT_W-1:0]     prog_q;
    logic [31:0]          status_word;
    logic                 status_wr;

    udma_xfer_count #(.CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_count (
        .clk(clk), .rst_n(rst_n), .start(dma_start), .prog_cnt(prog_q),
        .word_ack(word_ack), .dev_exit(dev_exit), .active(active),
        .nend_set(nend_set), .devtrm_set(devtrm_set)
    );

    udma_iferr_detect u_iferr (
        .active(active), .dir_in(dir_in), .burst_start(burst_start),
        .host_end(host_end), .dev_end(dev_end), .dreq(dreq), .iordy(iordy),
        .iferr_set(iferr_set)
    );

    udma_taskfile_gate #(.TF_AW(TF_AW), .TF_DW(TF_DW)) u_tf (
        .clk(clk), .rst_n(rst_n), .dma_active(active), .tf_req(tf_req),
        .tf_we(tf_we), .tf_addr(tf_addr), .tf_wdata(tf_wdata),
        .tf_rdata(tf_rdata), .tf_strobe(tf_strobe), .swerr_set(swerr_set)
    );

    // Gather set events in flag order (matches FLAG_POS)
    always_comb begin
        set_vec   = {swerr_set, iferr_set, devtrm_set, tout_evt, err_evt, nend_set};
        status_wr = cpu_wr && (cpu_addr == CPU_AW'(ADDR_STATUS));
    end

    // One sticky write-0-to-clear cell per flag; set beats clear
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        localparam int IDX = NUM_FLAGS - 1 - g;
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[IDX] <= 1'b0;
            else if (set_vec[IDX])
                flag_q[IDX] <= 1'b1;
            else if (status_wr && !cpu_wdata[FLAG_POS[g]])
                flag_q[IDX] <= 1'b0;
        end
    end

    // Programmed transfer byte count register
    always_ff @(posedge clk) begin
        if (!rst_n)
            prog_q <= '0;
        else if (cpu_wr && (cpu_addr == CPU_AW'(ADDR_COUNT)))
            prog_q <= cpu_wdata[CNT_W-1:0];
    end

    // Assemble the status word from flags and live bits
    always_comb begin
        status_word = '0;
        for (int i = 0; i < NUM_FLAGS; i++)
            status_word[FLAG_POS[i]] = flag_q[NUM_FLAGS-1-i];
        status_word[POS_DEVINT] = dev_irq;
        status_word[POS_ACT]    = active;
    end

    // Register read multiplexer
    always_comb begin
        cpu_rdata = '0;
        if (cpu_rd) begin
            if (cpu_addr == CPU_AW'(ADDR_STATUS))
                cpu_rdata = status_word;
            else if (cpu_addr == CPU_AW'(ADDR_COUNT))
                cpu_rdata = 32'(prog_q);
        end
    end
endmodule

// File: rtl/udma_status_mon_chk.sv
// Module: property checker for udma_status_mon, attached by bind.
// Assumes: the status word is observed through the internal assembled word.
module udma_status_mon_chk #(
    parameter int CPU_AW = 4,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [31:0]       cpu_wdata,
    input logic [31:0]       cpu_rdata,
    input logic              tf_req,
    input logic              tf_strobe,
    input logic              dma_start,
    input logic              word_ack,
    input logic              dev_exit,
    input logic [31:0]       status_word,
    input logic [CNT_W-1:0]  prog_q
);
    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr == '0) |-> (cpu_rdata[31:9] == '0 && !cpu_rdata[6]));

    assert_w0c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == '0 && !cpu_wdata[8] && !(tf_req && status_word[0]))
        |=> !status_word[8]);

    assert_w1_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[7] && cpu_wr && cpu_addr == '0 && cpu_wdata[7]) |=> status_word[7]);

    assert_blocked_sets_swerr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_req && status_word[0]) |=> status_word[8]);

    assert_blocked_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[0] |-> !tf_strobe);

    assert_start_goes_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_start && !status_word[0] && prog_q != '0) |=> status_word[0]);

    assert_zero_start_nend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_start && !status_word[0] && prog_q == '0) |=> status_word[1]);

    assert_exit_devtrm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[0] && dev_exit && !word_ack) |=> (status_word[5] && !status_word[0]));
endmodule

bind udma_status_mon udma_status_mon_chk #(.CPU_AW(CPU_AW), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .tf_req(tf_req), .tf_strobe(tf_strobe), .dma_start(dma_start),
    .word_ack(word_ack), .dev_exit(dev_exit), .status_word(status_word),
    .prog_q(prog_q)
);

// File: tb/udma_status_mon_bench.sv
// Bench: behavioural reference model compared against the design every cycle.
module udma_status_mon_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  cpu_addr;
    logic        cpu_rd, cpu_wr;
    logic [31:0] cpu_wdata, cpu_rdata;
    logic        tf_req, tf_we;
    logic [2:0]  tf_addr;
    logic [15:0] tf_wdata, tf_rdata;
    logic        tf_strobe;
    logic        dma_start, word_ack, dev_exit, dir_in, burst_start;
    logic        host_end, dev_end, dreq, iordy, tout_evt, err_evt, dev_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_sw, m_if, m_dt, m_to, m_er, m_ne, m_act, m_cnt, m_prog;
    int m_shadow [8];

    always #10 clk = ~clk;

    udma_status_mon u_udma_status_mon (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .tf_req(tf_req), .tf_we(tf_we), .tf_addr(tf_addr), .tf_wdata(tf_wdata),
        .tf_rdata(tf_rdata), .tf_strobe(tf_strobe), .dma_start(dma_start),
        .word_ack(word_ack), .dev_exit(dev_exit), .dir_in(dir_in),
        .burst_start(burst_start), .host_end(host_end), .dev_end(dev_end),
        .dreq(dreq), .iordy(iordy), .tout_evt(tout_evt), .err_evt(err_evt),
        .dev_irq(dev_irq)
    );

    task automatic chk(string req, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        cpu_addr = 0; cpu_rd = 1; cpu_wr = 0; cpu_wdata = '1;
        tf_req = 0; tf_we = 0; tf_addr = 0; tf_wdata = 0;
        dma_start = 0; word_ack = 0; dev_exit = 0; burst_start = 0;
        host_end = 0; dev_end = 0; dreq = 0; iordy = 1;
        tout_evt = 0; err_evt = 0;
    endtask

    task automatic model_reset();
        m_sw = 0; m_if = 0; m_dt = 0; m_to = 0; m_er = 0; m_ne = 0;
        m_act = 0; m_cnt = 0; m_prog = 0;
        foreach (m_shadow[i]) m_shadow[i] = 0;
    endtask

    // Compare all outputs against the model for the current inputs
    task automatic compare();
        logic [31:0] exp_rd;
        int exp_tfr;
        exp_rd = 0;
        if (cpu_rd && cpu_addr == 0) begin
            chk("R1 reserved", {cpu_rdata[31:9], cpu_rdata[6]}, 0);
            chk("R3 SWERR", cpu_rdata[8], m_sw);
            chk("R4,R5 IFERR", cpu_rdata[7], m_if);
            chk("R8 DEVTRM", cpu_rdata[5], m_dt);
            chk("R9 DEVINT", cpu_rdata[4], dev_irq);
            chk("R9 TOUT", cpu_rdata[3], m_to);
            chk("R9 ERR", cpu_rdata[2], m_er);
            chk("R7 NEND", cpu_rdata[1], m_ne);
            chk("R6 ACT", cpu_rdata[0], m_act);
        end else begin
            if (cpu_rd && cpu_addr == 1) exp_rd = 32'(m_prog);
            chk("R10 read mux", cpu_rdata, exp_rd);
        end
        chk("R3 strobe", tf_strobe, tf_req && !m_act);
        exp_tfr = (tf_req && !tf_we && !m_act) ? m_shadow[tf_addr] : 0;
        chk("R3 tf_rdata", tf_rdata, exp_tfr);
    endtask

    // Advance the model by one clock using the inputs held at the edge
    task automatic model_step();
        int ack, exh, dts, nes, ifs, sws, wst, clr;
        ack = m_act && word_ack;
        exh = ack && (m_cnt <= 2);
        dts = m_act && dev_exit && !exh;
        nes = exh || (dma_start && !m_act && m_prog == 0);
        ifs = m_act && (dir_in ?
                  ((host_end && (dreq || !iordy)) || (dev_end && !iordy)) :
                  ((burst_start && !iordy) || (host_end && (dreq || !iordy))));
        sws = tf_req && m_act;
        wst = cpu_wr && cpu_addr == 0;
        // R2: set wins, else zero-bit write clears
        clr = wst && !cpu_wdata[8]; m_sw = sws ? 1 : (clr ? 0 : m_sw);
        clr = wst && !cpu_wdata[7]; m_if = ifs ? 1 : (clr ? 0 : m_if);
        clr = wst && !cpu_wdata[5]; m_dt = dts ? 1 : (clr ? 0 : m_dt);
        clr = wst && !cpu_wdata[3]; m_to = tout_evt ? 1 : (clr ? 0 : m_to);
        clr = wst && !cpu_wdata[2]; m_er = err_evt ? 1 : (clr ? 0 : m_er);
        clr = wst && !cpu_wdata[1]; m_ne = nes ? 1 : (clr ? 0 : m_ne);
        if (tf_req && tf_we && !m_act) m_shadow[tf_addr] = tf_wdata;
        if (!m_act) begin
            if (dma_start && m_prog != 0) begin m_act = 1; m_cnt = m_prog; end
        end else if (exh || dev_exit) begin
            m_act = 0; m_cnt = 0;
        end else if (ack) begin
            m_cnt = m_cnt - 2;
        end
        if (cpu_wr && cpu_addr == 1) m_prog = cpu_wdata[15:0];
    endtask

    // One cycle: inputs were set at the falling edge
    task automatic cyc();
        #5 compare();
        @(posedge clk);
        if (rst_n) model_step(); else model_reset();
        @(negedge clk);
    endtask

    task automatic wr_reg(int a, logic [31:0] d);
        cpu_wr = 1; cpu_addr = 4'(a); cpu_wdata = d; cyc();
        cpu_wr = 0; cpu_addr = 0; cpu_wdata = '1;
    endtask

    task automatic pulse_start();
        dma_start = 1; cyc(); dma_start = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs(); dir_in = 1; dev_irq = 0; rst_n = 0;
        model_reset();
        @(negedge clk);
        repeat (3) cyc();
        rst_n = 1;
        // R1: reset state
        cyc();
        chk("R1 reset status", cpu_rdata, 0);

        // R10: count register and other addresses
        wr_reg(1, 32'h0000_0006);
        cpu_addr = 1; cyc(); cpu_addr = 5; cyc(); cpu_rd = 0; cpu_addr = 0; cyc();
        cpu_rd = 1;

        // R3: task-file write/read while idle
        tf_req = 1; tf_we = 1; tf_addr = 3; tf_wdata = 16'hBEEF; cyc();
        tf_we = 0; cyc(); tf_req = 0;

        // R6/R3: start, blocked accesses
        pulse_start(); cyc();
        tf_req = 1; tf_we = 1; tf_addr = 3; tf_wdata = 16'h1234; cyc();
        tf_we = 0; cyc(); tf_req = 0; cyc();
        // R4: data-in conditions with all dreq/iordy combos
        dir_in = 1;
        for (int k = 0; k < 4; k++) begin
            dreq = k[0]; iordy = k[1];
            host_end = 1; cyc(); host_end = 0; wr_reg(0, 32'hFFFF_FF7F);
            dev_end = 1; cyc(); dev_end = 0; wr_reg(0, 32'hFFFF_FF7F);
            burst_start = 1; cyc(); burst_start = 0; cyc();
        end
        // R5: data-out conditions
        dir_in = 0;
        for (int k = 0; k < 4; k++) begin
            dreq = k[0]; iordy = k[1];
            burst_start = 1; cyc(); burst_start = 0; wr_reg(0, 32'hFFFF_FF7F);
            host_end = 1; cyc(); host_end = 0; wr_reg(0, 32'hFFFF_FF7F);
            dev_end = 1; cyc(); dev_end = 0; cyc();
        end
        dreq = 0; iordy = 1;
        // R7: exhaust count (6 bytes = 3 words)
        word_ack = 1; repeat (3) cyc(); word_ack = 0; cyc();
        // R2: set and clear in the same cycle, then plain clear
        tout_evt = 1; cpu_wr = 1; cpu_wdata = 0; cyc();
        tout_evt = 0; cyc(); cpu_wr = 0; cpu_wdata = '1; cyc();
        // R8: device exit early, and exit on the final word
        pulse_start(); word_ack = 1; cyc(); word_ack = 0; dev_exit = 1; cyc();
        dev_exit = 0; cyc(); wr_reg(0, 0);
        pulse_start(); word_ack = 1; cyc(); cyc(); dev_exit = 1; cyc();
        word_ack = 0; dev_exit = 0; cyc();
        // R7: zero count start
        wr_reg(1, 0); pulse_start(); cyc();
        // R9: interrupt mirror and event strobes
        dev_irq = 1; wr_reg(0, 0); err_evt = 1; cyc(); err_evt = 0; dev_irq = 0; cyc();

        // Pseudo-random mix
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            cpu_wr   = (r < 12);
            cpu_addr = 4'((r < 8) ? 0 : (r < 11) ? 1 : $urandom_range(0, 3));
            cpu_rd   = ($urandom_range(0, 9) != 0);
            cpu_wdata = (cpu_addr == 1) ? 32'($urandom_range(0, 12)) : $urandom;
            tf_req = ($urandom_range(0, 9) < 2); tf_we = $urandom_range(0, 1);
            tf_addr = 3'($urandom_range(0, 7)); tf_wdata = 16'($urandom);
            dma_start = ($urandom_range(0, 19) == 0);
            word_ack = ($urandom_range(0, 2) == 0);
            dev_exit = ($urandom_range(0, 39) == 0);
            dir_in = $urandom_range(0, 1);
            burst_start = ($urandom_range(0, 9) == 0);
            host_end = ($urandom_range(0, 9) == 0);
            dev_end = ($urandom_range(0, 9) == 0);
            dreq = $urandom_range(0, 1); iordy = ($urandom_range(0, 3) != 0);
            tout_evt = ($urandom_range(0, 49) == 0);
            err_evt = ($urandom_range(0, 49) == 0);
            dev_irq = $urandom_range(0, 1);
            cyc();
        end
        idle_inputs(); cyc();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule